// File: doc/BRIEF.md
# Simple Dual-Port RAM with Selectable Read-During-Write Behaviour

This block is a synchronous memory with one write port and one read port. The write port stores a word at the rising edge of its clock when its enable is high. The read port returns the addressed word one read-clock edge after the request. The two ports may share one clock or run from separate clocks, which is set at elaboration. Two writes in the same cycle cannot happen, because only one port can write.

A collision is a read and a write of the same address in the same cycle. An elaboration-time mode sets what the read returns on a collision. Old mode returns the whole stored word from before the write. New mode forwards the word being written. Any mode gives no promise about the value. When the ports run from unrelated clocks, no mode gives a defined collision result.

A reader whose pipeline has stalled has two controls for keeping its data. Dropping the read enable freezes the output word. Raising the hold input makes the port keep reading the last captured address while the address input moves on.

Top module: `sdp_ram_rdw`

## Requirements
- R1: While `rst_n` is low at a rising `rd_clk` edge, `rd_data` becomes all zeros and the captured read address becomes 0.
- R2: When `wr_en` is high at a rising `wr_clk` edge, `wr_data` is stored at `wr_addr`. A later non-colliding read of that address returns the stored word.
- R3: When `rd_en` is high and `rd_hold` is low at a rising `rd_clk` edge, `rd_data` after that edge holds the word stored at `rd_addr`, which is one cycle of latency. That address is also captured as the held address.
- R4: When `rd_en` is low at a rising `rd_clk` edge, `rd_data` does not change, whatever the address, hold and write inputs do.
- R5: When `rd_en` and `rd_hold` are both high, the read uses the held address captured under R3 and ignores `rd_addr`. `rd_data` follows the current contents at the held address, so it picks up writes to that address.
- R6: With MODE = RDW_OLD (code 0) and COMMON_CLK = 1, a collision returns the complete word stored before that write.
- R7: With MODE = RDW_NEW (code 1) and COMMON_CLK = 1, a collision returns the `wr_data` of that same cycle.
- R8: With MODE = RDW_ANY (code 2), or with COMMON_CLK = 0, the collision result is unspecified. Every read that does not collide still follows R3, R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock (tied to `wr_clk` when COMMON_CLK = 1) |
| rst_n | input | 1 | Synchronous active-low reset, read clock domain |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address, AW = clog2(DEPTH) |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read clock enable; low freezes `rd_data` |
| rd_hold | input | 1 | Read from the held address instead of `rd_addr` |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data |

## Verification
Every read result appears one read-clock edge after the request. A write becomes visible to a non-colliding read that samples it at the next edge. The bench drives its inputs on the falling edge and works out the expected word from its reference array before that array takes the write. It then compares one time unit after the rising edge, which lines each comparison up with the single register in the read path. One bench drives three instances in parallel, one in each mode. The collision result of the Any instance is treated as unknown until the next enabled read that does not collide.

// File: rtl/sdp_rdw_pkg.sv
// Package: shared types for the simple dual-port RAM.
// Assumes: nothing; holds only the collision-mode encoding and a width helper.
package sdp_rdw_pkg;

    // Result of a same-address read and write in one cycle.
    typedef enum logic [1:0] {
        RDW_OLD = 2'd0,   // whole word from before the write
        RDW_NEW = 2'd1,   // word being written, forwarded
        RDW_ANY = 2'd2    // no promise
    } rdw_mode_e;

    // Address width for a given depth, at least one bit.
    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/sdp_rdw_store.sv
// Module: storage array with the write port and a combinational array read.
// Assumes: only this port writes; rd_addr stays below DEPTH; contents are not
// reset, so a word reads undefined until it has been written.
module sdp_rdw_store #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 6
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0] mem [DEPTH];

    // Write port: store one word per enabled write-clock edge.
    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Array read for the read-side output stage.
    assign rd_word = mem[rd_addr];

    AST_WRITE_LANDS: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R2

endmodule

// File: rtl/sdp_rdw_addr_hold.sv
// Module: read address selection with an address-hold register.
// Assumes: rd_hold is only meaningful together with rd_en; the held address
// is captured on every enabled, non-held read.
module sdp_rdw_addr_hold #(
    parameter int unsigned AW = 6
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_hold,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] eff_addr
);

    logic [AW-1:0] held_q;

    // Capture the presented address on each enabled, non-held read.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (rd_en && !rd_hold) begin
            held_q <= rd_addr;
        end
    end

    // Choose the held address while hold is asserted.
    assign eff_addr = rd_hold ? held_q : rd_addr;

    AST_HOLD_USES_CAPTURE: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_hold && $past(rst_n) && $past(rd_en && !rd_hold)) |-> eff_addr == $past(rd_addr)); // R5

endmodule

// File: rtl/sdp_rdw_out_stage.sv
// Module: collision handling and the registered read output.
// Assumes: wr_* signals are in the read clock domain when COMMON_CLK is set;
// otherwise no forwarding path is built and the collision result is undefined.
module sdp_rdw_out_stage
    import sdp_rdw_pkg::*;
#(
    parameter int unsigned DW         = 16,
    parameter int unsigned AW         = 6,
    parameter rdw_mode_e   MODE       = RDW_OLD,
    parameter bit          COMMON_CLK = 1'b1
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] eff_addr,
    input  logic [DW-1:0] rd_word,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    localparam bit FWD_EN = (MODE == RDW_NEW) && COMMON_CLK;

    logic          hit;
    logic [DW-1:0] next_word;

    // Detect a same-address write in the current cycle.
    assign hit = wr_en && (wr_addr == eff_addr);

    // Pick forwarded write data in new-data mode, else the stored word.
    assign next_word = (FWD_EN && hit) ? wr_data : rd_word;

    // Output register: cleared by reset, frozen while the enable is low.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= next_word;
        end
    end

    AST_STALL_KEEPS_DATA: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R4

    generate
        if (FWD_EN) begin : g_new_chk
            AST_NEW_FORWARDS: assert property (@(posedge rd_clk) disable iff (!rst_n)
                (rd_en && wr_en && wr_addr == eff_addr) |=> rd_data == $past(wr_data)); // R7
        end
        if (MODE == RDW_OLD && COMMON_CLK) begin : g_old_chk
            AST_OLD_WORD: assert property (@(posedge rd_clk) disable iff (!rst_n)
                (rd_en && wr_en && wr_addr == eff_addr) |=> rd_data == $past(rd_word)); // R6
        end
    endgenerate

endmodule

// File: rtl/sdp_ram_rdw.sv
// Module: simple dual-port RAM, one write port and one read port, with an
// elaboration-time read-during-write mode, read clock enable and address hold.
// Assumes: rd_clk and wr_clk are the same net when COMMON_CLK = 1; DEPTH > 0.
module sdp_ram_rdw
    import sdp_rdw_pkg::*;
#(
    parameter int unsigned DW         = 16,
    parameter int unsigned DEPTH      = 64,
    parameter rdw_mode_e   MODE       = RDW_OLD,
    parameter bit          COMMON_CLK = 1'b1,
    localparam int unsigned AW        = addr_bits(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          rd_hold,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [AW-1:0] eff_addr;
    logic [DW-1:0] rd_word;

    // Read address selection with hold.
    sdp_rdw_addr_hold #(.AW(AW)) u_addr (
        .rd_clk   (rd_clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_hold  (rd_hold),
        .rd_addr  (rd_addr),
        .eff_addr (eff_addr)
    );

    // Storage array and write port.
    sdp_rdw_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .wr_clk  (wr_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (eff_addr),
        .rd_word (rd_word)
    );

    // Collision handling and output register.
    sdp_rdw_out_stage #(.DW(DW), .AW(AW), .MODE(MODE), .COMMON_CLK(COMMON_CLK)) u_out (
        .rd_clk   (rd_clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .eff_addr (eff_addr),
        .rd_word  (rd_word),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/sdp_ram_rdw_bench.sv
// Bench: three instances (old, new, any) on one shared clock, checked against
// a behavioural reference array every cycle.
module sdp_ram_rdw_bench;
    import sdp_rdw_pkg::*;

    localparam int DW = 16;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_hold = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] q_old, q_new, q_any;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    int            held = 0;
    logic [DW-1:0] exp_old = '0, exp_new = '0, exp_any = '0;
    bit            any_known = 1;

    always #5 clk = ~clk;

    sdp_ram_rdw #(.DW(DW), .DEPTH(DEPTH), .MODE(RDW_OLD)) u_sdp_ram_rdw (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_hold(rd_hold), .rd_addr(rd_addr), .rd_data(q_old));
    sdp_ram_rdw #(.DW(DW), .DEPTH(DEPTH), .MODE(RDW_NEW)) u_sdp_ram_rdw_new (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_hold(rd_hold), .rd_addr(rd_addr), .rd_data(q_new));
    sdp_ram_rdw #(.DW(DW), .DEPTH(DEPTH), .MODE(RDW_ANY)) u_sdp_ram_rdw_any (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_hold(rd_hold), .rd_addr(rd_addr), .rd_data(q_any));

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, predict, compare after the rising edge.
    task automatic step(input bit rst, input bit we, input int wa, input logic [DW-1:0] wd,
                        input bit re, input bit hd, input int ra);
        int    eff;
        bit    coll;
        string tag;
        @(negedge clk);
        rst_n = rst; wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        rd_en = re; rd_hold = hd; rd_addr = AW'(ra);
        eff  = hd ? held : ra;
        coll = we && (wa == eff);
        if (!rst) begin
            tag = "R1"; exp_old = '0; exp_new = '0; exp_any = '0; any_known = 1; held = 0;
        end else if (!re) begin
            tag = "R4";
        end else begin
            tag = coll ? "R6 R7" : (hd ? "R5" : "R2 R3");
            exp_old = ref_mem[eff];
            exp_new = coll ? wd : ref_mem[eff];
            exp_any = ref_mem[eff];
            any_known = !coll;
            if (!hd) held = ra;
        end
        if (we && rst) ref_mem[wa] = wd;
        @(posedge clk); #1;
        check({tag, " old"}, q_old, exp_old);
        check({tag, " new"}, q_new, exp_new);
        if (any_known) check({"R8 ", tag, " any"}, q_any, exp_any);
    endtask

    initial begin
        // R1: reset clears the output.
        for (int i = 0; i < 3; i++) step(0, 0, 0, '0, 1, 0, 5);
        // R2: fill every word, reading the word written one cycle earlier.
        for (int a = 0; a < DEPTH; a++) begin
            step(1, 1, a, DW'((a * 37 + 5) ^ 16'hA5A5), a > 0, 0, (a > 0) ? a - 1 : 0);
        end
        // R3: sequential reads, no writes.
        for (int a = DEPTH - 1; a >= 0; a--) step(1, 0, 0, '0, 1, 0, a);
        // R4: stalled reader, addresses and writes moving.
        step(1, 0, 0, '0, 1, 0, 12);
        for (int i = 0; i < 8; i++) step(1, 1, 12 + i, DW'(16'h1000 + i), 0, i[0], 40 + i);
        // R5: hold address 10 while the input address moves, then write address 10.
        step(1, 0, 0, '0, 1, 0, 10);
        step(1, 0, 0, '0, 1, 1, 20);
        step(1, 0, 0, '0, 1, 1, 21);
        step(1, 1, 10, 16'hBEEF, 1, 1, 22);   // collision on held address (R6 R7)
        step(1, 0, 0, '0, 1, 1, 23);          // both modes now see the new word
        step(1, 0, 0, '0, 1, 0, 24);
        // R6 R7: direct same-address collisions.
        for (int i = 0; i < 6; i++) step(1, 1, 30 + i, DW'(16'h5A00 + i), 1, 0, 30 + i);
        step(1, 1, 30, 16'hFFFF, 1, 0, 30);
        step(1, 1, 30, 16'h0000, 1, 0, 30);
        // Reset again mid-run, then mixed random traffic over a small window.
        step(0, 0, 0, '0, 1, 0, 3);
        for (int i = 0; i < 3000; i++) begin
            step(1, ($urandom % 2) == 1, int'($urandom % 8), DW'($urandom),
                 ($urandom % 4) != 0, ($urandom % 4) == 0, int'($urandom % 8));
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule